// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block drives a single serial control line from a time-switch's connection memory. Each memory word belongs to one output stream and one channel. One bit of that word is the per-channel control flag. Once per frame the block reads the flag of every stream/channel entry and shifts it out, one bit per bit clock. The flag for a channel goes out during the channel period before that channel appears on the TDM streams. External line circuitry latched from this line therefore has a full channel period to act before the traffic arrives.

Inside a channel period there are as many bit slots as there are streams. Slot 0 carries stream 0, and each later slot carries the next stream. The block keeps a frame position counter that a frame pulse aligns. From that counter it computes which memory entry belongs to the next bit slot, presents the address on a combinational read port, and registers the returned flag onto the output. The block does not write the connection memory.

Top module: `ctl_bit_serializer`

## Requirements
- R1: After reset the control output is 0, and it stays 0 until a clock edge samples `frame_i` high.
- R2: The first clock edge that samples `frame_i` high starts the following cycle as TDM channel 0, bit slot 0. Without further pulses the position advances one slot per clock and wraps from channel 31 slot 7 back to channel 0 slot 0.
- R3: During bit slot s of TDM channel c, `ctrl_o` equals bit 1 of the memory word for stream s, channel c+1.
- R4: Inside one channel period the streams are sent in ascending order, stream 0 in slot 0 through stream 7 in slot 7.
- R5: During TDM channel 31 the output carries the flags of channel 0, so the sequence wraps across the frame boundary.
- R6: Across one full frame of 256 cycles, every one of the 256 memory entries is sent exactly once, in the order given by R3.
- R7: The read address is stream*32 + channel, with the stream in address bits 7:5 and the channel in bits 4:0. The memory is read again for every slot, so a word changed before the edge that loads its slot is sent with its new value.
- R8: A frame pulse in the middle of a frame moves the block back to channel 0, slot 0 in the cycle that follows the pulse.
- R9: Only bit 1 of the memory word affects the output. The other seven bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one control bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame pulse; a sampled high starts channel 0 on the next cycle |
| cm_addr_o | output | 8 | Connection memory read address for the next bit slot |
| cm_data_i | input | 8 | Connection memory word returned for `cm_addr_o` in the same cycle |
| ctrl_o | output | 1 | Serial control bit stream |

## Verification
The checker expects the connection memory to answer combinationally, so that `cm_data_i` belongs to the address presented in the same cycle. It also expects frame pulses to be single-cycle, synchronous to the bit clock. The bench models the memory as an array that is read directly from `cm_addr_o`. It drives `frame_i` and all memory writes only on falling edges, so every word is settled before the rising edge that loads it. Random memory images, mid-frame pulses and late writes all keep to those two assumptions.

// File: rtl/ctl_ser_pkg.sv
package ctl_ser_pkg;

   // How stream and channel are packed into the memory address
   typedef enum logic {
      LAYOUT_STREAM_HIGH  = 1'b0,
      LAYOUT_CHANNEL_HIGH = 1'b1
   } addr_layout_e;

   localparam int unsigned DEF_STREAMS  = 8;
   localparam int unsigned DEF_CHANNELS = 32;
   localparam int unsigned DEF_WORD_W   = 8;
   localparam int unsigned DEF_CTRL_BIT = 1;
   localparam int unsigned DEF_LEAD_CH  = 1;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ctl_ser_pos_ctr.sv
module ctl_ser_pos_ctr #(
   parameter int unsigned NUM_STREAMS  = ctl_ser_pkg::DEF_STREAMS,
   parameter int unsigned NUM_CHANNELS = ctl_ser_pkg::DEF_CHANNELS,
   localparam int unsigned ST_W = $clog2(NUM_STREAMS),
   localparam int unsigned CH_W = $clog2(NUM_CHANNELS)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            frame_i,
   output logic [ST_W-1:0] nxt_slot_o,
   output logic [CH_W-1:0] nxt_chan_o,
   output logic            nxt_locked_o
);

   localparam logic [ST_W-1:0] LAST_SLOT = ST_W'(NUM_STREAMS - 1);
   localparam logic [CH_W-1:0] LAST_CHAN = CH_W'(NUM_CHANNELS - 1);

   logic [ST_W-1:0] slot_q;
   logic [CH_W-1:0] chan_q;
   logic            locked_q;

   // Position the block will hold in the next cycle
   always_comb begin
      nxt_slot_o = slot_q;
      nxt_chan_o = chan_q;
      if (frame_i) begin
         nxt_slot_o = '0;
         nxt_chan_o = '0;
      end else if (slot_q == LAST_SLOT) begin
         nxt_slot_o = '0;
         nxt_chan_o = (chan_q == LAST_CHAN) ? '0 : chan_q + 1'b1;
      end else begin
         nxt_slot_o = slot_q + 1'b1;
      end
      nxt_locked_o = locked_q | frame_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_q   <= '0;
         chan_q   <= '0;
         locked_q <= 1'b0;
      end else begin
         slot_q   <= nxt_slot_o;
         chan_q   <= nxt_chan_o;
         locked_q <= nxt_locked_o;
      end
   end

endmodule

// File: rtl/ctl_ser_addr_map.sv
module ctl_ser_addr_map #(
   parameter int unsigned NUM_STREAMS  = ctl_ser_pkg::DEF_STREAMS,
   parameter int unsigned NUM_CHANNELS = ctl_ser_pkg::DEF_CHANNELS,
   parameter int unsigned LEAD_CH      = ctl_ser_pkg::DEF_LEAD_CH,
   parameter ctl_ser_pkg::addr_layout_e ADDR_LAYOUT = ctl_ser_pkg::LAYOUT_STREAM_HIGH,
   localparam int unsigned ST_W   = $clog2(NUM_STREAMS),
   localparam int unsigned CH_W   = $clog2(NUM_CHANNELS),
   localparam int unsigned ADDR_W = ST_W + CH_W
) (
   input  logic [ST_W-1:0]   slot_i,
   input  logic [CH_W-1:0]   chan_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [CH_W-1:0] LEAD = CH_W'(LEAD_CH);

   logic [CH_W-1:0] tgt_chan;
   logic [ST_W-1:0] tgt_stream;

   // Power-of-two channel count lets the lead wrap by truncation
   assign tgt_chan   = chan_i + LEAD;
   assign tgt_stream = slot_i;

   generate
      if (ADDR_LAYOUT == ctl_ser_pkg::LAYOUT_STREAM_HIGH) begin : g_stream_high
         assign addr_o = {tgt_stream, tgt_chan};
      end else begin : g_channel_high
         assign addr_o = {tgt_chan, tgt_stream};
      end
   endgenerate

endmodule

// File: rtl/ctl_ser_out_stage.sv
module ctl_ser_out_stage #(
   parameter int unsigned WORD_W   = ctl_ser_pkg::DEF_WORD_W,
   parameter int unsigned CTRL_BIT = ctl_ser_pkg::DEF_CTRL_BIT
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [WORD_W-1:0] word_i,
   input  logic              locked_i,
   output logic              ctrl_o
);

   logic flag;
   logic ctrl_q;

   assign flag = word_i[CTRL_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= 1'b0;
      else         ctrl_q <= locked_i & flag;
   end

   assign ctrl_o = ctrl_q;

endmodule

// File: rtl/ctl_bit_serializer.sv
module ctl_bit_serializer #(
   parameter int unsigned NUM_STREAMS  = ctl_ser_pkg::DEF_STREAMS,
   parameter int unsigned NUM_CHANNELS = ctl_ser_pkg::DEF_CHANNELS,
   parameter int unsigned WORD_W       = ctl_ser_pkg::DEF_WORD_W,
   parameter int unsigned CTRL_BIT     = ctl_ser_pkg::DEF_CTRL_BIT,
   parameter int unsigned LEAD_CH      = ctl_ser_pkg::DEF_LEAD_CH,
   parameter ctl_ser_pkg::addr_layout_e ADDR_LAYOUT = ctl_ser_pkg::LAYOUT_STREAM_HIGH,
   localparam int unsigned ST_W   = $clog2(NUM_STREAMS),
   localparam int unsigned CH_W   = $clog2(NUM_CHANNELS),
   localparam int unsigned ADDR_W = ST_W + CH_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frame_i,
   output logic [ADDR_W-1:0] cm_addr_o,
   input  logic [WORD_W-1:0] cm_data_i,
   output logic              ctrl_o
);

   // Elaboration-time parameter checks
   generate
      if (!ctl_ser_pkg::is_pow2(NUM_STREAMS) || NUM_STREAMS < 2) begin : g_bad_streams
         $error("NUM_STREAMS must be a power of two, at least 2");
      end
      if (!ctl_ser_pkg::is_pow2(NUM_CHANNELS) || NUM_CHANNELS < 2) begin : g_bad_channels
         $error("NUM_CHANNELS must be a power of two, at least 2");
      end
      if (CTRL_BIT >= WORD_W) begin : g_bad_bit
         $error("CTRL_BIT must lie inside the memory word");
      end
      if (LEAD_CH >= NUM_CHANNELS) begin : g_bad_lead
         $error("LEAD_CH must be smaller than NUM_CHANNELS");
      end
   endgenerate

   logic [ST_W-1:0] nxt_slot;
   logic [CH_W-1:0] nxt_chan;
   logic            nxt_locked;

   ctl_ser_pos_ctr #(
      .NUM_STREAMS (NUM_STREAMS),
      .NUM_CHANNELS(NUM_CHANNELS)
   ) u_pos (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .frame_i     (frame_i),
      .nxt_slot_o  (nxt_slot),
      .nxt_chan_o  (nxt_chan),
      .nxt_locked_o(nxt_locked)
   );

   ctl_ser_addr_map #(
      .NUM_STREAMS (NUM_STREAMS),
      .NUM_CHANNELS(NUM_CHANNELS),
      .LEAD_CH     (LEAD_CH),
      .ADDR_LAYOUT (ADDR_LAYOUT)
   ) u_map (
      .slot_i(nxt_slot),
      .chan_i(nxt_chan),
      .addr_o(cm_addr_o)
   );

   ctl_ser_out_stage #(
      .WORD_W  (WORD_W),
      .CTRL_BIT(CTRL_BIT)
   ) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .word_i  (cm_data_i),
      .locked_i(nxt_locked),
      .ctrl_o  (ctrl_o)
   );

endmodule

// File: rtl/ctl_bit_serializer_chk.sv
module ctl_bit_serializer_chk #(
   parameter int unsigned NUM_STREAMS  = 8,
   parameter int unsigned NUM_CHANNELS = 32,
   parameter int unsigned WORD_W       = 8,
   parameter int unsigned CTRL_BIT     = 1,
   parameter int unsigned LEAD_CH      = 1,
   parameter ctl_ser_pkg::addr_layout_e ADDR_LAYOUT = ctl_ser_pkg::LAYOUT_STREAM_HIGH,
   localparam int unsigned ST_W   = $clog2(NUM_STREAMS),
   localparam int unsigned CH_W   = $clog2(NUM_CHANNELS),
   localparam int unsigned ADDR_W = ST_W + CH_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              frame_i,
   input logic [ADDR_W-1:0] cm_addr_o,
   input logic [WORD_W-1:0] cm_data_i,
   input logic              ctrl_o
);

   logic seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      seen_q <= 1'b0;
      else if (frame_i) seen_q <= 1'b1;
   end

   function automatic logic [ST_W-1:0] stream_of(input logic [ADDR_W-1:0] a);
      if (ADDR_LAYOUT == ctl_ser_pkg::LAYOUT_STREAM_HIGH) return a[ADDR_W-1 -: ST_W];
      else return a[ST_W-1:0];
   endfunction

   function automatic logic [CH_W-1:0] chan_of(input logic [ADDR_W-1:0] a);
      if (ADDR_LAYOUT == ctl_ser_pkg::LAYOUT_STREAM_HIGH) return a[CH_W-1:0];
      else return a[ADDR_W-1 -: CH_W];
   endfunction

   // R1
   quiet_before_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen_q |-> (ctrl_o == 1'b0));

   // R3
   flag_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q || frame_i) |=> (ctrl_o == $past(cm_data_i[CTRL_BIT])));

   // R4
   stream_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_i |=> (frame_i ||
         stream_of(cm_addr_o) == ST_W'(stream_of($past(cm_addr_o)) + 1'b1)));

   // R8
   frame_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_i |=> (frame_i ||
         (stream_of(cm_addr_o) == ST_W'(1) && chan_of(cm_addr_o) == CH_W'(LEAD_CH))));

endmodule

bind ctl_bit_serializer ctl_bit_serializer_chk #(
   .NUM_STREAMS (NUM_STREAMS),
   .NUM_CHANNELS(NUM_CHANNELS),
   .WORD_W      (WORD_W),
   .CTRL_BIT    (CTRL_BIT),
   .LEAD_CH     (LEAD_CH),
   .ADDR_LAYOUT (ADDR_LAYOUT)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .frame_i  (frame_i),
   .cm_addr_o(cm_addr_o),
   .cm_data_i(cm_data_i),
   .ctrl_o   (ctrl_o)
);

// File: tb/ctl_bit_serializer_bench.sv
module ctl_bit_serializer_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       fp    = 1'b0;
   logic [7:0] mem [256];
   logic [7:0] rd_addr;
   logic [7:0] rd_data;
   logic       ctrl;

   assign rd_data = mem[rd_addr];

   ctl_bit_serializer u_ctl_bit_serializer (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .frame_i  (fp),
      .cm_addr_o(rd_addr),
      .cm_data_i(rd_data),
      .ctrl_o   (ctrl)
   );

   int errors = 0;
   int checks = 0;
   int pos    = 0;
   bit done   = 0;

   // {tdm channel[4:0], slot[2:0], word[7:0]}
   localparam logic [15:0] VEC [8] = '{
      {5'd0,  3'd0, 8'h02}, {5'd0,  3'd7, 8'hFD},
      {5'd8,  3'd0, 8'h02}, {5'd8,  3'd7, 8'h02},
      {5'd31, 3'd0, 8'h02}, {5'd31, 3'd5, 8'hFD},
      {5'd15, 3'd3, 8'hFF}, {5'd20, 3'd6, 8'h00}
   };

   function automatic int addr_of(input int stream, input int chan);
      return stream * 32 + chan;
   endfunction

   function automatic logic exp_bit(input int p);
      return mem[addr_of(p % 8, (p / 8 + 1) % 32)][1];
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s pos=%0d actual=%0b expected=%0b", req, pos, act, exp);
      end
   endtask

   task automatic sync();
      @(negedge clk) fp = 1'b1;
      @(negedge clk) fp = 1'b0;
      pos = 0;
   endtask

   task automatic adv();
      @(negedge clk);
      pos = (pos + 1) % 256;
   endtask

   task automatic go_to(input int t);
      while (pos != t) adv();
   endtask

   task automatic fill_random();
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      check("R1", ctrl, 1'b0);
      rst_n = 1'b1;
      // R1: all flags high, yet the output stays 0 without a frame pulse
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check("R1", ctrl, 1'b0);
      end

      // Vector table: R3, R4, R5, R9
      for (int v = 0; v < 8; v++) begin
         int ch = int'(VEC[v][15:11]);
         int sl = int'(VEC[v][10:8]);
         for (int i = 0; i < 256; i++) mem[i] = ~VEC[v][7:0];
         mem[addr_of(sl, (ch + 1) % 32)] = VEC[v][7:0];
         sync();
         go_to(ch * 8 + sl);
         check(ch == 31 ? "R5" : "R3", ctrl, VEC[v][1]);
      end

      // R6: random image, two full frames without realignment (R2 wrap)
      fill_random();
      sync();
      for (int i = 0; i < 512; i++) begin
         check(i < 256 ? "R6" : "R2", ctrl, exp_bit(pos));
         adv();
      end

      // R7: a write made just before the loading edge is sent at once
      go_to(40);
      mem[addr_of(1, 6)] = ~mem[addr_of(1, 6)];
      adv();
      check("R7", ctrl, exp_bit(41));
      go_to(100);
      mem[addr_of(4, 14)] = mem[addr_of(4, 14)] ^ 8'h02;
      go_to(108);
      check("R7", ctrl, exp_bit(108));

      // R8: realign mid-frame
      go_to(130);
      sync();
      for (int i = 0; i < 16; i++) begin
         check("R8", ctrl, exp_bit(pos));
         adv();
      end

      // R9: toggle every non-flag bit, output unchanged
      go_to(60);
      mem[addr_of(5, 8)] = mem[addr_of(5, 8)] ^ 8'hFD;
      go_to(61);
      check("R9", ctrl, exp_bit(61));

      // R1: reset returns the output to 0 until a fresh pulse
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         check("R1", ctrl, 1'b0);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule